// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds waiting instructions for a single functional-unit type in an out-of-order core. An upstream rename stage dispatches an instruction with an opcode, two source operands and a destination tag. Each operand comes with a flag. When the flag is set, the field already holds the data. When it is clear, the low bits of the field name the tag of the instruction that will produce the data. The block keeps a small number of stations. It stalls dispatch when all of them are occupied.

Finished results reach the stations over a shared result bus. Several finishing units request the bus at once, and a hardwired priority arbiter picks one of them each cycle. The winner's tag and value are broadcast, and every waiting operand holding that tag captures the value. When both operands of a station are present, the station becomes a candidate for issue. The oldest candidate is presented to the functional unit on a valid/ready interface.

Dispatch is a valid/ready interface. A transfer happens on a rising edge with `disp_valid` and `disp_ready` both high. `disp_ready` depends only on station occupancy. Issue is also valid/ready. `iss_valid` never drops while `iss_ready` is low. The offered instruction may be replaced only by an older one that became ready in the meantime. Units that lose arbitration must keep their request and payload until granted.

Top module: `tag_station_array`

## Requirements
- R1: After reset every station is free, so `disp_ready` is 1 and `iss_valid` is 0.
- R2: `disp_ready` is 0 exactly when all stations are occupied. A transfer fills the lowest-numbered free station, and that station holds the instruction from the next cycle on.
- R3: Operand encoding: flag 1 means the field is the data. Flag 0 means field bits [TAG_W-1:0] are the producer tag. A ready operand is issued bit-for-bit as dispatched.
- R4: While `cdb_valid` is 1, every occupied station with a flag-0 operand whose tag equals `cdb_tag` stores `cdb_val` in that operand at the edge and sets its flag. The station can issue from the next cycle.
- R5: If a flag-0 dispatched operand's tag equals `cdb_tag` in the transfer cycle, the broadcast value is captured at dispatch.
- R6: `iss_valid` is 1 exactly when some occupied station has both flags set. A station leaves at an edge with `iss_valid` and `iss_ready` high, and it can be refilled from the next cycle.
- R7: Among ready stations, the one dispatched earliest is offered. If ages are equal, the lowest index is offered.
- R8: While `iss_ready` is 0, no station is released and `iss_valid` stays 1 once raised.
- R9: `fu_gnt` is one-hot among the requesting units, with unit 0 having the highest priority. `cdb_valid` equals the OR of `fu_req`. `cdb_tag` and `cdb_val` carry the winner's payload in the same cycle. Losers are not granted.
- R10: A broadcast has no effect on operands whose flag is already set, even when their data bits equal the broadcast tag.
- R11: The opcode and destination tag are presented unchanged on `iss_op` and `iss_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | A station is free |
| disp_op | input | OP_W | Opcode |
| disp_a_is_val | input | 1 | Operand A flag |
| disp_a | input | DATA_W | Operand A data or tag |
| disp_b_is_val | input | 1 | Operand B flag |
| disp_b | input | DATA_W | Operand B data or tag |
| disp_dst | input | TAG_W | Destination tag |
| iss_valid | output | 1 | A ready instruction is offered |
| iss_ready | input | 1 | Functional unit accepts (not stalled) |
| iss_op | output | OP_W | Offered opcode |
| iss_a | output | DATA_W | Offered operand A |
| iss_b | output | DATA_W | Offered operand B |
| iss_dst | output | TAG_W | Offered destination tag |
| fu_req | input | N_UNIT | Bus requests from finishing units |
| fu_tag | input | N_UNIT*TAG_W | Result tags, unit u at bits [u*TAG_W +: TAG_W] |
| fu_val | input | N_UNIT*DATA_W | Result values, unit u at bits [u*DATA_W +: DATA_W] |
| fu_gnt | output | N_UNIT | Bus grant, one-hot |
| cdb_valid | output | 1 | Broadcast valid |
| cdb_tag | output | TAG_W | Broadcast tag |
| cdb_val | output | DATA_W | Broadcast value |

## Verification
The grant and the broadcast are combinational, so they are due in the same cycle as the requests. A dispatch shows on the issue port one edge after the transfer. A capture makes the station eligible one edge after the broadcast. A station released by issue is back in `disp_ready` one edge later. The bench drives inputs at the falling edge. It then samples one time unit later, against a behavioural model that has advanced exactly one state per rising edge, so each result is compared in the cycle it is due.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int TSA_STATIONS = 4;
  localparam int TSA_TAG_W    = 6;
  localparam int TSA_DATA_W   = 32;
  localparam int TSA_OP_W     = 4;
  localparam int TSA_UNITS    = 3;
endpackage

// File: rtl/tsa_operand.sv
module tsa_operand #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              load,
  input  logic              load_is_val,
  input  logic [DATA_W-1:0] load_fld,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  output logic              have,
  output logic [DATA_W-1:0] fld
);
  logic hit_at_load;
  logic hit_waiting;

  assign hit_at_load = cdb_valid && (load_fld[TAG_W-1:0] == cdb_tag);
  assign hit_waiting = live && !have && cdb_valid && (fld[TAG_W-1:0] == cdb_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have <= 1'b0;
      fld  <= '0;
    end else if (load) begin
      have <= load_is_val || hit_at_load;
      fld  <= (!load_is_val && hit_at_load) ? cdb_val : load_fld;
    end else if (hit_waiting) begin
      have <= 1'b1;
      fld  <= cdb_val;
    end
  end

  // R4
  snoop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !load && !have && cdb_valid && fld[TAG_W-1:0] == cdb_tag)
      |=> (have && fld == $past(cdb_val)));

  // R10
  held_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have && !load) |=> (have && $stable(fld)));
endmodule

// File: rtl/tsa_station.sv
module tsa_station #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              release_i,
  input  logic [OP_W-1:0]   d_op,
  input  logic              d_a_is_val,
  input  logic [DATA_W-1:0] d_a,
  input  logic              d_b_is_val,
  input  logic [DATA_W-1:0] d_b,
  input  logic [TAG_W-1:0]  d_dst,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [TAG_W-1:0]  dst_o
);
  logic a_have, b_have;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      op_o   <= '0;
      dst_o  <= '0;
    end else if (alloc) begin
      busy_o <= 1'b1;
      op_o   <= d_op;
      dst_o  <= d_dst;
    end else if (release_i) begin
      busy_o <= 1'b0;
    end
  end

  tsa_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_a (
    .clk(clk), .rst_n(rst_n), .live(busy_o), .load(alloc),
    .load_is_val(d_a_is_val), .load_fld(d_a),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
    .have(a_have), .fld(a_o));

  tsa_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_b (
    .clk(clk), .rst_n(rst_n), .live(busy_o), .load(alloc),
    .load_is_val(d_b_is_val), .load_fld(d_b),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
    .have(b_have), .fld(b_o));

  assign ready_o = busy_o && a_have && b_have;

  // R2
  alloc_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy_o);

  // R6
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> !busy_o);
endmodule

// File: rtl/tsa_age_select.sv
module tsa_age_select #(
  parameter int N_STN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_STN-1:0] alloc,
  input  logic [N_STN-1:0] ready,
  output logic [N_STN-1:0] pick,
  output logic             any
);
  // older[i][j] set: station i was filled before station j
  logic [N_STN-1:0] older [N_STN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_STN; i++) older[i] <= '0;
    end else begin
      for (int k = 0; k < N_STN; k++) begin
        if (alloc[k]) begin
          for (int j = 0; j < N_STN; j++) begin
            if (j != k) begin
              older[k][j] <= 1'b0;
              older[j][k] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_STN; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < N_STN; j++) begin
        if (j != i && ready[j]) begin
          if (older[j][i]) beaten = 1'b1;
          else if (!older[i][j] && j < i) beaten = 1'b1;
        end
      end
      pick[i] = ready[i] && !beaten;
    end
  end

  assign any = |ready;

  // R7
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  // R6
  pick_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready) |-> (|pick));
endmodule

// File: rtl/tsa_bus_arb.sv
module tsa_bus_arb #(
  parameter int N_UNIT = 3,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_UNIT-1:0]        req,
  input  logic [N_UNIT*TAG_W-1:0]  req_tag,
  input  logic [N_UNIT*DATA_W-1:0] req_val,
  output logic [N_UNIT-1:0]        gnt,
  output logic                     bus_valid,
  output logic [TAG_W-1:0]         bus_tag,
  output logic [DATA_W-1:0]        bus_val
);
  logic [N_UNIT:0] taken;

  always_comb begin
    taken[0] = 1'b0;
    for (int u = 0; u < N_UNIT; u++) begin
      gnt[u]     = req[u] && !taken[u];
      taken[u+1] = taken[u] || req[u];
    end
  end

  always_comb begin
    bus_tag = '0;
    bus_val = '0;
    for (int u = 0; u < N_UNIT; u++) begin
      if (gnt[u]) begin
        bus_tag = req_tag[u*TAG_W +: TAG_W];
        bus_val = req_val[u*DATA_W +: DATA_W];
      end
    end
  end

  assign bus_valid = taken[N_UNIT];

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R9
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R9
  top_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);
endmodule

// File: rtl/tag_station_array.sv
module tag_station_array
  import tsa_pkg::*;
#(
  parameter int N_STN  = TSA_STATIONS,
  parameter int TAG_W  = TSA_TAG_W,
  parameter int DATA_W = TSA_DATA_W,
  parameter int OP_W   = TSA_OP_W,
  parameter int N_UNIT = TSA_UNITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  input  logic [OP_W-1:0]          disp_op,
  input  logic                     disp_a_is_val,
  input  logic [DATA_W-1:0]        disp_a,
  input  logic                     disp_b_is_val,
  input  logic [DATA_W-1:0]        disp_b,
  input  logic [TAG_W-1:0]         disp_dst,
  output logic                     iss_valid,
  input  logic                     iss_ready,
  output logic [OP_W-1:0]          iss_op,
  output logic [DATA_W-1:0]        iss_a,
  output logic [DATA_W-1:0]        iss_b,
  output logic [TAG_W-1:0]         iss_dst,
  input  logic [N_UNIT-1:0]        fu_req,
  input  logic [N_UNIT*TAG_W-1:0]  fu_tag,
  input  logic [N_UNIT*DATA_W-1:0] fu_val,
  output logic [N_UNIT-1:0]        fu_gnt,
  output logic                     cdb_valid,
  output logic [TAG_W-1:0]         cdb_tag,
  output logic [DATA_W-1:0]        cdb_val
);
  localparam int ALLOC_CHAIN = N_STN + 1;

  logic [N_STN-1:0]       busy, ready, alloc, pick, release_v;
  logic [ALLOC_CHAIN-1:0] free_seen;
  logic                   take;
  logic [OP_W-1:0]        st_op  [N_STN];
  logic [DATA_W-1:0]      st_a   [N_STN];
  logic [DATA_W-1:0]      st_b   [N_STN];
  logic [TAG_W-1:0]       st_dst [N_STN];

  tsa_bus_arb #(.N_UNIT(N_UNIT), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(fu_req), .req_tag(fu_tag), .req_val(fu_val),
    .gnt(fu_gnt), .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_val(cdb_val));

  assign disp_ready = !(&busy);
  assign take       = disp_valid && disp_ready;

  always_comb begin
    free_seen[0] = 1'b0;
    for (int i = 0; i < N_STN; i++) begin
      alloc[i]       = take && !busy[i] && !free_seen[i];
      free_seen[i+1] = free_seen[i] || !busy[i];
    end
  end

  generate
    for (genvar g = 0; g < N_STN; g++) begin : g_stn
      tsa_station #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_stn (
        .clk(clk), .rst_n(rst_n),
        .alloc(alloc[g]), .release_i(release_v[g]),
        .d_op(disp_op), .d_a_is_val(disp_a_is_val), .d_a(disp_a),
        .d_b_is_val(disp_b_is_val), .d_b(disp_b), .d_dst(disp_dst),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
        .busy_o(busy[g]), .ready_o(ready[g]),
        .op_o(st_op[g]), .a_o(st_a[g]), .b_o(st_b[g]), .dst_o(st_dst[g]));
    end
  endgenerate

  tsa_age_select #(.N_STN(N_STN)) u_sel (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .ready(ready),
    .pick(pick), .any(iss_valid));

  assign release_v = pick & {N_STN{iss_ready}};

  always_comb begin
    iss_op  = '0;
    iss_a   = '0;
    iss_b   = '0;
    iss_dst = '0;
    for (int i = 0; i < N_STN; i++) begin
      if (pick[i]) begin
        iss_op  = st_op[i];
        iss_a   = st_a[i];
        iss_b   = st_b[i];
        iss_dst = st_dst[i];
      end
    end
  end

  // R8
  offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> iss_valid);

  // R2
  full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && !(iss_valid && iss_ready)) |=> !disp_ready);
endmodule

// File: tb/tag_station_array_bench.sv
module tag_station_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, TW = 6, DW = 32, OW = 4, NU = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic disp_valid, disp_ready, disp_a_is_val, disp_b_is_val;
  logic [OW-1:0] disp_op, iss_op;
  logic [DW-1:0] disp_a, disp_b, iss_a, iss_b, cdb_val;
  logic [TW-1:0] disp_dst, iss_dst, cdb_tag;
  logic iss_valid, iss_ready, cdb_valid;
  logic [NU-1:0] fu_req, fu_gnt;
  logic [NU*TW-1:0] fu_tag;
  logic [NU*DW-1:0] fu_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_station_array u_tag_station_array (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_op(disp_op), .disp_a_is_val(disp_a_is_val), .disp_a(disp_a),
    .disp_b_is_val(disp_b_is_val), .disp_b(disp_b), .disp_dst(disp_dst),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .iss_dst(iss_dst),
    .fu_req(fu_req), .fu_tag(fu_tag), .fu_val(fu_val), .fu_gnt(fu_gnt),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val));

  int checks = 0, errors = 0;
  bit done = 0;
  string pay_req = "R3";
  string vld_req = "R6";

  // reference model state
  bit          m_busy [NS];
  bit          m_af [NS], m_bf [NS];
  logic [DW-1:0] m_a [NS], m_b [NS];
  logic [OW-1:0] m_op [NS];
  logic [TW-1:0] m_dst [NS];
  int          age_q [$];
  bit          u_pend [NU];
  logic [TW-1:0] u_tag [NU];
  logic [DW-1:0] u_val [NU];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply_units();
    for (int u = 0; u < NU; u++) begin
      fu_req[u] = u_pend[u];
      fu_tag[u*TW +: TW] = u_tag[u];
      fu_val[u*DW +: DW] = u_val[u];
    end
  endtask

  task automatic post(int u, logic [TW-1:0] t, logic [DW-1:0] v);
    u_pend[u] = 1; u_tag[u] = t; u_val[u] = v;
  endtask

  task automatic offer(logic [OW-1:0] op, bit av, logic [DW-1:0] a,
                       bit bv, logic [DW-1:0] b, logic [TW-1:0] dst);
    disp_valid = 1; disp_op = op; disp_a_is_val = av; disp_a = a;
    disp_b_is_val = bv; disp_b = b; disp_dst = dst;
  endtask

  // one clock: compare at negedge+1, advance model, wait next negedge
  task automatic step(output bit accepted);
    bit e_dr, e_iv;
    int sel, win, slot;
    apply_units();
    #1;
    e_dr = 0;
    slot = -1;
    for (int i = 0; i < NS; i++) if (!m_busy[i]) begin
      e_dr = 1;
      if (slot < 0) slot = i;
    end
    sel = -1;
    foreach (age_q[k]) if (sel < 0 && m_af[age_q[k]] && m_bf[age_q[k]]) sel = age_q[k];
    e_iv = (sel >= 0);
    win = -1;
    for (int u = 0; u < NU; u++) if (win < 0 && u_pend[u]) win = u;

    chk(disp_ready == e_dr, "R2", "disp_ready", 64'(disp_ready), 64'(e_dr));
    chk(iss_valid == e_iv, vld_req, "iss_valid", 64'(iss_valid), 64'(e_iv));
    if (e_iv && iss_valid) begin
      chk(iss_a == m_a[sel], pay_req, "iss_a", 64'(iss_a), 64'(m_a[sel]));
      chk(iss_b == m_b[sel], pay_req, "iss_b", 64'(iss_b), 64'(m_b[sel]));
      chk(iss_op == m_op[sel], "R11", "iss_op", 64'(iss_op), 64'(m_op[sel]));
      chk(iss_dst == m_dst[sel], "R11", "iss_dst", 64'(iss_dst), 64'(m_dst[sel]));
    end
    begin
      logic [NU-1:0] e_g;
      e_g = '0;
      if (win >= 0) e_g[win] = 1'b1;
      chk(fu_gnt == e_g, "R9", "fu_gnt", 64'(fu_gnt), 64'(e_g));
      chk(cdb_valid == (win >= 0), "R9", "cdb_valid", 64'(cdb_valid), 64'(win >= 0));
      if (win >= 0) begin
        chk(cdb_tag == u_tag[win], "R9", "cdb_tag", 64'(cdb_tag), 64'(u_tag[win]));
        chk(cdb_val == u_val[win], "R9", "cdb_val", 64'(cdb_val), 64'(u_val[win]));
      end
    end

    // next state
    accepted = disp_valid && e_dr;
    if (e_iv && iss_ready) begin
      m_busy[sel] = 0;
      foreach (age_q[k]) if (age_q[k] == sel) begin age_q.delete(k); break; end
    end
    if (win >= 0) begin
      for (int i = 0; i < NS; i++) if (m_busy[i]) begin
        if (!m_af[i] && m_a[i][TW-1:0] == u_tag[win]) begin m_af[i] = 1; m_a[i] = u_val[win]; end
        if (!m_bf[i] && m_b[i][TW-1:0] == u_tag[win]) begin m_bf[i] = 1; m_b[i] = u_val[win]; end
      end
    end
    if (accepted) begin
      m_busy[slot] = 1; m_op[slot] = disp_op; m_dst[slot] = disp_dst;
      m_af[slot] = disp_a_is_val; m_a[slot] = disp_a;
      m_bf[slot] = disp_b_is_val; m_b[slot] = disp_b;
      if (win >= 0 && !disp_a_is_val && disp_a[TW-1:0] == u_tag[win]) begin
        m_af[slot] = 1; m_a[slot] = u_val[win];
      end
      if (win >= 0 && !disp_b_is_val && disp_b[TW-1:0] == u_tag[win]) begin
        m_bf[slot] = 1; m_b[slot] = u_val[win];
      end
      age_q.push_back(slot);
    end
    if (win >= 0) u_pend[win] = 0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    bit acc;
    disp_valid = 0;
    for (int k = 0; k < n; k++) step(acc);
  endtask

  task automatic push_one(logic [OW-1:0] op, bit av, logic [DW-1:0] a,
                          bit bv, logic [DW-1:0] b, logic [TW-1:0] dst);
    bit acc;
    offer(op, av, a, bv, b, dst);
    step(acc);
    disp_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    rst_n = 0; disp_valid = 0; disp_op = 0; disp_a_is_val = 0; disp_a = 0;
    disp_b_is_val = 0; disp_b = 0; disp_dst = 0; iss_ready = 0;
    for (int u = 0; u < NU; u++) begin u_pend[u] = 0; u_tag[u] = 0; u_val[u] = 0; end
    for (int i = 0; i < NS; i++) m_busy[i] = 0;
    apply_units();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(disp_ready == 1'b1, "R1", "reset disp_ready", 64'(disp_ready), 64'd1);
    chk(iss_valid == 1'b0, "R1", "reset iss_valid", 64'(iss_valid), 64'd0);

    // fill with ready operands while the unit is stalled
    vld_req = "R8"; pay_req = "R3";
    for (int k = 0; k < 4; k++)
      push_one(OW'(k + 1), 1, 32'h1000_0000 + 32'(k), 1, 32'h2000_0000 + 32'(k), TW'(20 + k));
    offer(4'd5, 1, 32'h1000_0004, 1, 32'h2000_0004, 6'd24);
    step(acc);
    chk(acc == 0, "R2", "full window accepted", 64'(acc), 64'd0);
    iss_ready = 1; vld_req = "R6"; pay_req = "R7";
    step(acc);
    step(acc);
    chk(acc == 1, "R2", "slot reuse after issue", 64'(acc), 64'd1);
    disp_valid = 0;
    idle(6);

    // wakeup through the bus, one and two waiting operands
    pay_req = "R4";
    push_one(4'd6, 0, 32'd5, 1, 32'h0000_0BBB, 6'd30);
    idle(2);
    post(0, 6'd5, 32'hAAAA_5555);
    idle(3);
    push_one(4'd7, 0, 32'd7, 0, 32'd8, 6'd31);
    post(1, 6'd7, 32'h7777_0001);
    post(2, 6'd8, 32'h8888_0002);
    idle(5);

    // capture in the dispatch cycle
    pay_req = "R5";
    post(0, 6'd9, 32'h9999_9999);
    push_one(4'd8, 0, 32'd9, 1, 32'h0000_0C0C, 6'd32);
    idle(3);

    // ready operand whose data bits look like the broadcast tag
    pay_req = "R10";
    push_one(4'd9, 1, 32'h0000_000C, 0, 32'd3, 6'd33);
    post(0, 6'd12, 32'hDEAD_BEEF);
    idle(2);
    post(1, 6'd3, 32'h0303_0303);
    idle(3);

    // mixed traffic
    pay_req = "R7";
    for (int c = 0; c < 4000; c++) begin
      for (int u = 0; u < NU; u++)
        if (!u_pend[u] && $urandom_range(0, 9) < 3)
          post(u, TW'($urandom_range(0, 7)), $urandom);
      iss_ready = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 1) == 1)
        offer(OW'($urandom), $urandom_range(0, 1) == 1, {$urandom_range(0, 3) == 0 ? $urandom : 32'($urandom_range(0, 7))},
              $urandom_range(0, 1) == 1, 32'($urandom_range(0, 7)), TW'($urandom));
      else
        disp_valid = 0;
      step(acc);
    end
    iss_ready = 1;
    for (int t = 0; t < 8; t++) post(t % NU, TW'(t), 32'hF000_0000 + 32'(t));
    idle(40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule